// File: doc/BRIEF.md
# Dual-Enable Asynchronous Static RAM Model

This block is a synthesizable functional model of an 8192-word, 8-bit asynchronous static RAM. It stands in for an external memory device inside a self-checking testbench. It has two chip selects of opposite sense: `e1_ni` is active low and `e2_i` is active high. It also has an active-low write strobe `we_ni` and an active-low output gate `oe_ni`. The bidirectional data bus is split into a data input, a data output and a drive-enable. Reads are purely combinational from the address and the control pins. The drive-enable tells a testbench exactly when the model would be driving the shared bus.

A write is open while both selects are asserted and the strobe is low. The write closes on whichever control leaves that state first: the strobe rising, `e1_ni` rising or `e2_i` falling. The model observes the pins on a sampling clock. The word is committed at the first sampling edge at which the write is seen closed, and it uses the address and data present at that edge. The memory array has no reset, so retention across standby and across a reset of the sampling logic can be observed.

An optional timing monitor, counted in sampling-clock cycles, flags three faults: data that was not settled before the write closed, address or data that moved too soon after it closed, and an address that changed while a write was open.

Top module: `async_sram_model`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (8192 by 8 by default), each address storing its word independently, including addresses 0 and 8191.
- R2: When `e1_ni` is 1 or `e2_i` is 0 the model is in standby: `data_oe_o` is 0, `data_o` is 0, and a low `we_ni` stores nothing.
- R3: A write is open while `e1_ni`=0, `e2_i`=1 and `we_ni`=0; the level of `oe_ni` has no effect on what is stored.
- R4: With `e1_ni`=0, `e2_i`=1, `we_ni`=1 and `oe_ni`=0, `data_oe_o` is 1 and `data_o` equals the stored word at `addr_i`, following address changes with no clock edge.
- R5: With both selects asserted, `we_ni`=1 and `oe_ni`=1, `data_oe_o` is 0 and `data_o` is 0.
- R6: While `we_ni` is 0, `data_oe_o` is 0 regardless of `oe_ni`. Once `we_ni` returns to 1 with the read conditions met, the bus is driven again.
- R7: A write is closed by the first of three events: `we_ni` rising, `e1_ni` rising or `e2_i` falling. The word on `data_i` at the first sampling edge where the write is seen closed is stored at the `addr_i` of that edge, and it is readable right after that edge.
- R8: Reset (`rst_ni`=0) clears only the sampling and flag state: all three flags read 0 and stored words survive both reset and standby.
- R9: `setup_err_o` is 1 for exactly the one cycle after a closing edge when `data_i` at that edge differed from its value at any of the previous SETUP_CYC sampling edges (default 1).
- R10: `hold_err_o` is 1 for one cycle after any of the HOLD_CYC sampling edges that follow a closing edge at which `addr_i` or `data_i` differs from the previous edge (default 1).
- R11: `addr_err_o` is 1 for one cycle after a sampling edge at which a write was open at this and the previous edge and `addr_i` changed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for write commit and timing checks |
| rst_ni | input | 1 | Asynchronous active-low reset of the sampling state |
| addr_i | input | ADDR_W | Word address |
| e1_ni | input | 1 | Chip select, active low |
| e2_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output gate, active low |
| data_i | input | DATA_W | Write data, the input half of the bus |
| data_o | output | DATA_W | Read data, 0 when not driving |
| data_oe_o | output | 1 | 1 when the model drives the bus |
| setup_err_o | output | 1 | Data setup violation pulse |
| hold_err_o | output | 1 | Address or data hold violation pulse |
| addr_err_o | output | 1 | Address moved during an open write |

## Verification
The bench closes writes by each of the three controls in turn. A model that listened to only the strobe would leave a word unwritten when a select dropped first. It changes the data in the same half-cycle as the closing edge: a model that latched data one edge early would store the stale value and stay silent on `setup_err_o`. It moves data one cycle after the close and moves the address mid-write; a monitor off by a cycle would pulse the wrong flag, pulse it late or pulse it not at all. Strobe-low writes in standby, a mid-run reset, and address changes during a read between clock edges expose models that write while deselected, clear the array, or register the read path.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef struct packed {
    logic enabled;
    logic wr_open;
    logic rd_drive;
  } sram_ctl_t;

  localparam int unsigned DefAddrW = 13;
  localparam int unsigned DefDataW = 8;

endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
  import sram_model_pkg::*;
(
  input  logic      e1_ni,
  input  logic      e2_i,
  input  logic      we_ni,
  input  logic      oe_ni,
  output sram_ctl_t ctl_o
);

  logic sel;

  assign sel = ~e1_ni & e2_i;

  always_comb begin
    ctl_o.enabled  = sel;
    ctl_o.wr_open  = sel & ~we_ni;
    ctl_o.rd_drive = sel & we_ni & ~oe_ni;
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_open_i,
  output logic wr_q_o,
  output logic commit_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q_o <= 1'b0;
    else         wr_q_o <= wr_open_i;
  end

  // first sample at which an open write is seen closed, by any control
  assign commit_o = wr_q_o & ~wr_open_i;

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  // no reset: contents persist through reset and standby
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sram_timing_mon.sv
module sram_timing_mon #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_q_i,
  input  logic              wr_open_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              setup_err_o,
  output logic              hold_err_o,
  output logic              addr_err_o
);

  localparam int unsigned RunW  = $clog2(SETUP_CYC + 2);
  localparam int unsigned HoldW = $clog2(HOLD_CYC + 2);
  localparam logic [RunW-1:0]  RunMax  = RunW'(SETUP_CYC);
  localparam logic [HoldW-1:0] HoldLen = HoldW'(HOLD_CYC);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [RunW-1:0]   run_q, run_now;
  logic [HoldW-1:0]  hold_q;
  logic              addr_same, data_same;

  assign addr_same = (addr_i == addr_q);
  assign data_same = (data_i == data_q);

  // consecutive edges at which data held its value, saturating
  always_comb begin
    if (!data_same)          run_now = '0;
    else if (run_q == RunMax) run_now = run_q;
    else                      run_now = run_q + RunW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      data_q      <= '0;
      run_q       <= '0;
      hold_q      <= '0;
      setup_err_o <= 1'b0;
      hold_err_o  <= 1'b0;
      addr_err_o  <= 1'b0;
    end else begin
      addr_q      <= addr_i;
      data_q      <= data_i;
      run_q       <= run_now;
      setup_err_o <= commit_i & (run_now < RunMax);
      addr_err_o  <= wr_q_i & wr_open_i & ~addr_same;
      hold_err_o  <= (hold_q != '0) & ~(addr_same & data_same);
      if (commit_i)           hold_q <= HoldLen;
      else if (hold_q != '0)  hold_q <= hold_q - HoldW'(1);
    end
  end

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W       = DefAddrW,
  parameter int unsigned DATA_W       = DefDataW,
  parameter bit          CHECK_TIMING = 1'b1,
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned HOLD_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              e1_ni,
  input  logic              e2_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              setup_err_o,
  output logic              hold_err_o,
  output logic              addr_err_o
);

  sram_ctl_t         ctl;
  logic              wr_q, commit;
  logic [DATA_W-1:0] rdata;

  sram_ctl_decode u_decode (
    .e1_ni (e1_ni),
    .e2_i  (e2_i),
    .we_ni (we_ni),
    .oe_ni (oe_ni),
    .ctl_o (ctl)
  );

  sram_wr_seq u_wr_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_open_i (ctl.wr_open),
    .wr_q_o    (wr_q),
    .commit_o  (commit)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (addr_i),
    .wdata_i (data_i),
    .raddr_i (addr_i),
    .rdata_o (rdata)
  );

  assign data_oe_o = ctl.rd_drive;
  assign data_o    = ctl.rd_drive ? rdata : '0;

  if (CHECK_TIMING) begin : g_mon
    sram_timing_mon #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
    ) u_mon (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_q_i      (wr_q),
      .wr_open_i   (ctl.wr_open),
      .commit_i    (commit),
      .addr_i      (addr_i),
      .data_i      (data_i),
      .setup_err_o (setup_err_o),
      .hold_err_o  (hold_err_o),
      .addr_err_o  (addr_err_o)
    );
  end else begin : g_no_mon
    assign setup_err_o = 1'b0;
    assign hold_err_o  = 1'b0;
    assign addr_err_o  = 1'b0;
  end

endmodule

// File: rtl/sram_model_chk.sv
module sram_model_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              e1_ni,
  input logic              e2_i,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              setup_err_o,
  input logic              hold_err_o,
  input logic              addr_err_o
);

  logic wr_c, wr_q, end_c, standby_c;

  assign wr_c      = !e1_ni && e2_i && !we_ni;
  assign standby_c = e1_ni || !e2_i;
  assign end_c     = wr_q && !wr_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_c;
  end

  assert_standby_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_c |-> (!data_oe_o && data_o == '0));

  assert_gate_closed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_c && we_ni && oe_ni) |-> (!data_oe_o && data_o == '0));

  assert_strobe_floats_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !data_oe_o);

  assert_write_visible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_c |=> (!(addr_i == $past(addr_i) && data_oe_o) || data_o == $past(data_i)));

  assert_word_retained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o) && $stable(addr_i) && !$past(end_c)) |-> $stable(data_o));

  assert_setup_flag_after_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_err_o |-> $past(end_c));

  assert_addr_flag_in_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> $past(wr_c));

endmodule

bind async_sram_model sram_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .e1_ni       (e1_ni),
  .e2_i        (e2_i),
  .we_ni       (we_ni),
  .oe_ni       (oe_ni),
  .data_i      (data_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .setup_err_o (setup_err_o),
  .hold_err_o  (hold_err_o),
  .addr_err_o  (addr_err_o)
);

// File: tb/async_sram_model_test.sv
module async_sram_model_test;

  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          e1_n = 1'b1, e2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doe, serr, herr, aerr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [DW-1:0] exp_mem [1 << AW];
  bit            exp_vld [1 << AW];

  always #4 clk = ~clk;

  async_sram_model uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .e1_ni       (e1_n),
    .e2_i        (e2),
    .we_ni       (we_n),
    .oe_ni       (oe_n),
    .data_i      (din),
    .data_o      (dout),
    .data_oe_o   (doe),
    .setup_err_o (serr),
    .hold_err_o  (herr),
    .addr_err_o  (aerr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    return exp_mem[a];
  endfunction

  task automatic go_idle();
    e1_n = 1'b1; e2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic chk_flags(input string req);
    chk(serr == 1'b0, {req, " setup flag quiet"}, serr, 0);
    chk(herr == 1'b0, {req, " hold flag quiet"}, herr, 0);
    chk(aerr == 1'b0, {req, " addr flag quiet"}, aerr, 0);
  endtask

  // mode 0: strobe rises, 1: e1 rises, 2: e2 falls
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int mode, input bit g);
    @(negedge clk);
    addr = a; din = d; oe_n = g; e1_n = 1'b0; e2 = 1'b1; we_n = 1'b0;
    #1 chk(doe == 1'b0, "R6 strobe low floats bus", doe, 0);
    @(negedge clk);
    case (mode)
      0:       we_n = 1'b1;
      1:       e1_n = 1'b1;
      default: e2 = 1'b0;
    endcase
    @(negedge clk);
    #1 chk_flags("R9 clean write");
    go_idle();
    exp_mem[a] = d;
    exp_vld[a] = 1'b1;
    @(negedge clk);
    #1 chk_flags("R10 clean write");
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a; e1_n = 1'b0; e2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    #1 chk(doe == 1'b1, "R4 read drives", doe, 1);
    if (exp_vld[a]) chk(dout == exp_word(a), req, dout, exp_word(a));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1 chk(doe == 1'b0, "R8 reset state drive", doe, 0);
    chk_flags("R8 reset state");
    rst_n = 1'b1;

    // R1 R3 R7: ends of the range, all three closing controls, both gate levels
    do_write(13'd0,    8'hA5, 0, 1'b1);
    do_write(13'd8191, 8'h5A, 1, 1'b0);
    do_write(13'd100,  8'h3C, 2, 1'b0);
    do_read(13'd0,    "R1 word at address 0");
    do_read(13'd8191, "R1 word at top address");
    do_read(13'd100,  "R7 close by e2 falling");
    do_read(13'd8191, "R3 gate low during write ignored");

    // R4: address change between edges
    do_read(13'd0, "R4 first address");
    #1 addr = 13'd8191;
    #1 chk(dout == 8'h5A, "R4 combinational address follow", dout, 8'h5A);

    // R5
    @(negedge clk);
    e1_n = 1'b0; e2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    #1 chk(doe == 1'b0, "R5 gate high no drive", doe, 0);
    chk(dout == '0, "R5 gate high data zero", dout, 0);

    // R6: drive returns once strobe rises
    @(negedge clk);
    addr = 13'd200; din = 8'h11; oe_n = 1'b0; we_n = 1'b0;
    #1 chk(doe == 1'b0, "R6 strobe low with gate low", doe, 0);
    @(negedge clk);
    we_n = 1'b1;
    #1 chk(doe == 1'b1, "R6 drive back after strobe", doe, 1);
    @(negedge clk);
    #1 chk(dout == 8'h11, "R7 word readable after close", dout, 8'h11);
    exp_mem[200] = 8'h11; exp_vld[200] = 1'b1;
    go_idle();
    @(negedge clk);

    // R2: strobe low while deselected either way
    @(negedge clk);
    addr = 13'd0; din = 8'hFF; e1_n = 1'b1; e2 = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    #1 chk(doe == 1'b0, "R2 e1 high no drive", doe, 0);
    chk(dout == '0, "R2 e1 high data zero", dout, 0);
    @(negedge clk);
    e1_n = 1'b0; e2 = 1'b0;
    #1 chk(doe == 1'b0, "R2 e2 low no drive", doe, 0);
    @(negedge clk);
    go_idle();
    do_read(13'd0, "R2 standby blocks write");

    // R8: reset keeps contents
    @(negedge clk);
    go_idle();
    rst_n = 1'b0;
    #1 chk_flags("R8 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(13'd8191, "R8 retained over reset");
    do_read(13'd100,  "R8 retained over standby");

    // R9: data moves with the closing edge
    @(negedge clk);
    addr = 13'd300; din = 8'h21; oe_n = 1'b1; e1_n = 1'b0; e2 = 1'b1; we_n = 1'b0;
    @(negedge clk);
    din = 8'h42; we_n = 1'b1;
    @(negedge clk);
    #1 chk(serr == 1'b1, "R9 setup flag raised", serr, 1);
    go_idle();
    @(negedge clk);
    #1 chk(serr == 1'b0, "R9 setup flag one cycle", serr, 0);
    exp_mem[300] = 8'h42; exp_vld[300] = 1'b1;
    do_read(13'd300, "R7 data of closing edge stored");

    // R10: data moves one edge after close
    @(negedge clk);
    addr = 13'd400; din = 8'h77; oe_n = 1'b1; e1_n = 1'b0; e2 = 1'b1; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    go_idle(); din = 8'h88;
    #1 chk(herr == 1'b0, "R10 hold flag not early", herr, 0);
    @(negedge clk);
    #1 chk(herr == 1'b1, "R10 hold flag raised", herr, 1);
    @(negedge clk);
    #1 chk(herr == 1'b0, "R10 hold flag one cycle", herr, 0);
    exp_mem[400] = 8'h77; exp_vld[400] = 1'b1;
    do_read(13'd400, "R10 stored value before move");

    // R11: address moves inside an open write
    @(negedge clk);
    addr = 13'd500; din = 8'h99; oe_n = 1'b1; e1_n = 1'b0; e2 = 1'b1; we_n = 1'b0;
    @(negedge clk);
    addr = 13'd501;
    @(negedge clk);
    #1 chk(aerr == 1'b1, "R11 addr flag raised", aerr, 1);
    we_n = 1'b1;
    @(negedge clk);
    #1 chk(aerr == 1'b0, "R11 addr flag one cycle", aerr, 0);
    go_idle();
    @(negedge clk);
    exp_mem[501] = 8'h99; exp_vld[501] = 1'b1;
    do_read(13'd501, "R11 word lands at final address");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(0, 31))
                                      : AW'(8160 + $urandom_range(0, 31));
      if ($urandom_range(0, 2) < 2)
        do_write(a, DW'($urandom_range(0, 255)), int'($urandom_range(0, 2)),
                 1'($urandom_range(0, 1)));
      else
        do_read(a, "R7 random readback");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule